// File: doc/BRIEF.md
# Bad-Block Table Builder

At start-up this block walks every erase block of a NAND device, from the lowest block number to the highest. For each block it asks a host-side bus sequencer for a single byte from the spare area of the block's first page, and it records the answer in a one-bit-per-block table. A byte of all ones means the block is usable. Any other value marks the block as unusable.

When the walk ends, the block pulses a completion strobe and reports the number of usable blocks. It raises a fault flag if that number is below a configured minimum. From then on it answers table queries for address mapping, one query per cycle. A separate port lets later logic mark a block unusable after a failed program or erase. The block never writes to or erases the device; it only reads the marker.

The controller has five states. The transitions are:
- IDLE → ISSUE on a start request.
- ISSUE → WAIT when the sequencer accepts the read.
- WAIT → ADVANCE when the response byte arrives.
- ADVANCE → ISSUE for the next block, or ADVANCE → READY after the last block.
- READY → ISSUE on a new start request, which rebuilds the table from scratch.

Top module: `bbt_builder`

## Requirements
- R1: A start request in IDLE or READY begins a scan at block 0. The scan issues exactly one read per block in ascending block order, through block NUM_BLOCKS-1, and no read is issued in READY.
- R2: A read request stays asserted with an unchanged row address until the sequencer accepts it. Only one read is outstanding at a time.
- R3: Each read targets the first page of its block: row = block × PAGES_PER_BLOCK (default 32). The spare-area byte offset is MARKER_OFF (default 5, which is absolute column 517), and the spare-read select output is 1.
- R4: A response byte of 8'hFF records the block as good (table bit 0). Any other byte records it as bad (table bit 1).
- R5: After a scan, good_count equals the number of blocks whose marker byte was 8'hFF.
- R6: device_fault is 1 only while the table is valid and good_count < MIN_GOOD (default 2013). A count equal to MIN_GOOD is not a fault.
- R7: scan_done is a single-cycle pulse, asserted in the first cycle in which table_valid is 1.
- R8: query_bad shows the table bit for the block presented on query_block one clock earlier. It reads 1 if the table was not valid in that cycle or if the block number is NUM_BLOCKS or higher.
- R9: mark_bad_valid with an in-range block while the table is valid sets that block's bit and decrements good_count if the block was good. Marking a block that is already bad changes nothing, and marking during a scan is ignored.
- R10: After reset the state is IDLE: no read requested, table_valid 0, good_count 0, scan_done 0, device_fault 0, query_bad 1.
- R11: A start request during a scan is ignored; the running scan continues without restarting.
- R12: A start request in READY invalidates the table, clears the count and rebuilds both from the new marker bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin (or rebuild) the scan |
| rd_req_valid | output | 1 | Marker read requested |
| rd_req_ready | input | 1 | Sequencer accepts the request |
| rd_req_row | output | ROW_W | Row (page) address of the first page of the block |
| rd_req_spare | output | 1 | 1 = spare-area read |
| rd_req_off | output | 4 | Byte offset inside the spare area |
| rd_rsp_valid | input | 1 | Marker byte returned |
| rd_rsp_byte | input | 8 | Marker byte value |
| mark_bad_valid | input | 1 | Mark a block bad after a failed operation |
| mark_bad_block | input | BLK_W | Block to mark |
| query_block | input | BLK_W | Block to look up |
| query_bad | output | 1 | Lookup result, one cycle later (1 = unusable) |
| table_valid | output | 1 | Scan finished, table usable |
| scan_busy | output | 1 | Scan in progress |
| scan_done | output | 1 | One-cycle completion pulse |
| good_count | output | CNT_W | Number of good blocks |
| device_fault | output | 1 | Good blocks below minimum |

## Verification
The assertions check the following properties every cycle:
- A pending request holds steady until it is accepted.
- The completion pulse lasts one cycle and coincides with the table becoming valid.
- Queries answer bad while the table is not valid.
- The fault flag appears only with a valid table.
- The good count never rises while the table is valid.

Only the bench scenarios can show the following behaviour:
- The ascending block order and the row and offset values of each read.
- The per-block table contents for two different marker patterns.
- The count arithmetic, including the boundary at exactly the minimum.
- That marks and start requests made during a scan are ignored, and that a rescan discards the previous table.

// File: rtl/bbt_pkg.sv
package bbt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ISSUE   = 3'd1,
        ST_WAIT    = 3'd2,
        ST_ADVANCE = 3'd3,
        ST_READY   = 3'd4
    } scan_state_t;

    localparam logic [7:0] GOOD_MARK = 8'hFF;

    function automatic logic marker_is_bad(input logic [7:0] b);
        return b != GOOD_MARK;
    endfunction

endpackage

// File: rtl/bbt_scan_fsm.sv
module bbt_scan_fsm
    import bbt_pkg::*;
#(
    parameter int NUM_BLOCKS      = 2048,
    parameter int PAGES_PER_BLOCK = 32,
    localparam int BLK_W          = $clog2(NUM_BLOCKS),
    localparam int PG_SHIFT       = $clog2(PAGES_PER_BLOCK),
    localparam int ROW_W          = BLK_W + PG_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rd_req_ready,
    input  logic             rd_rsp_valid,
    input  logic [7:0]       rd_rsp_byte,
    output logic             rd_req_valid,
    output logic [ROW_W-1:0] rd_req_row,
    output logic [BLK_W-1:0] cur_blk,
    output logic             rec_valid,
    output logic             rec_bad,
    output logic             clear_tbl,
    output logic             table_ready,
    output logic             scan_busy,
    output logic             scan_done
);

    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

    scan_state_t state_q, state_d;
    logic [BLK_W-1:0] blk_q;
    logic             done_q;
    logic             is_last;

    assign is_last = (blk_q == LAST_BLK);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_ISSUE;
            ST_ISSUE:   if (rd_req_ready) state_d = ST_WAIT;
            ST_WAIT:    if (rd_rsp_valid) state_d = ST_ADVANCE;
            ST_ADVANCE: state_d = is_last ? ST_READY : ST_ISSUE;
            ST_READY:   if (start) state_d = ST_ISSUE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs: block counter and completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_ADVANCE) && is_last;
            if (clear_tbl)
                blk_q <= '0;
            else if (state_q == ST_ADVANCE && !is_last)
                blk_q <= blk_q + 1'b1;
        end
    end

    // combinational outputs
    always_comb begin
        clear_tbl    = start && (state_q == ST_IDLE || state_q == ST_READY);
        rd_req_valid = (state_q == ST_ISSUE);
        rec_valid    = (state_q == ST_WAIT) && rd_rsp_valid;
        rec_bad      = marker_is_bad(rd_rsp_byte);
        table_ready  = (state_q == ST_READY);
        scan_busy    = (state_q == ST_ISSUE) || (state_q == ST_WAIT) ||
                       (state_q == ST_ADVANCE);
    end

    assign rd_req_row = ROW_W'(blk_q) << PG_SHIFT;
    assign cur_blk    = blk_q;
    assign scan_done  = done_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_row)); // R2

    AST_NO_REQ_READY: assert property (@(posedge clk) disable iff (!rst_n)
        table_ready |-> !rd_req_valid); // R1

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done); // R7

    AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> table_ready && $rose(table_ready)); // R7

endmodule

// File: rtl/bbt_bitmap.sv
module bbt_bitmap #(
    parameter int NUM_BLOCKS = 2048,
    localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [BLK_W-1:0] wr_blk,
    input  logic             wr_bad,
    input  logic             mark_en,
    input  logic [BLK_W-1:0] mark_blk,
    input  logic [BLK_W-1:0] rd_blk,
    output logic             rd_bad,
    output logic             mark_was_bad
);

    logic [NUM_BLOCKS-1:0] bad_q;

    // unscanned entries read as bad
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bad_q <= '1;
        end else if (clr) begin
            bad_q <= '1;
        end else begin
            if (wr_en)   bad_q[wr_blk]   <= wr_bad;
            if (mark_en) bad_q[mark_blk] <= 1'b1;
        end
    end

    assign rd_bad       = bad_q[rd_blk];
    assign mark_was_bad = bad_q[mark_blk];

    AST_MARK_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        mark_en && !clr && !wr_en |=> bad_q[$past(mark_blk)]); // R9

endmodule

// File: rtl/bbt_counter.sv
module bbt_counter #(
    parameter int NUM_BLOCKS = 2048,
    parameter int MIN_GOOD   = 2013,
    localparam int CNT_W     = $clog2(NUM_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             below_min
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (clr)              cnt_q <= '0;
        else if (inc && !dec)      cnt_q <= cnt_q + 1'b1;
        else if (dec && !inc && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign count     = cnt_q;
    assign below_min = (cnt_q < CNT_W'(MIN_GOOD));

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(NUM_BLOCKS)); // R5

endmodule

// File: rtl/bbt_builder.sv
module bbt_builder #(
    parameter int NUM_BLOCKS      = 2048,
    parameter int PAGES_PER_BLOCK = 32,
    parameter int MIN_GOOD        = 2013,
    parameter int MARKER_OFF      = 5,
    localparam int BLK_W          = $clog2(NUM_BLOCKS),
    localparam int ROW_W          = BLK_W + $clog2(PAGES_PER_BLOCK),
    localparam int CNT_W          = $clog2(NUM_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             rd_req_valid,
    input  logic             rd_req_ready,
    output logic [ROW_W-1:0] rd_req_row,
    output logic             rd_req_spare,
    output logic [3:0]       rd_req_off,
    input  logic             rd_rsp_valid,
    input  logic [7:0]       rd_rsp_byte,
    input  logic             mark_bad_valid,
    input  logic [BLK_W-1:0] mark_bad_block,
    input  logic [BLK_W-1:0] query_block,
    output logic             query_bad,
    output logic             table_valid,
    output logic             scan_busy,
    output logic             scan_done,
    output logic [CNT_W-1:0] good_count,
    output logic             device_fault
);

    logic [BLK_W-1:0] cur_blk;
    logic             rec_valid, rec_bad, clear_tbl, table_ready;
    logic             tbl_rd_bad, mark_was_bad, mark_en, below_min;
    logic             query_bad_q;

    localparam logic [BLK_W:0] N_BLK = (BLK_W + 1)'(NUM_BLOCKS);

    bbt_scan_fsm #(
        .NUM_BLOCKS      (NUM_BLOCKS),
        .PAGES_PER_BLOCK (PAGES_PER_BLOCK)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .rd_req_ready (rd_req_ready),
        .rd_rsp_valid (rd_rsp_valid),
        .rd_rsp_byte  (rd_rsp_byte),
        .rd_req_valid (rd_req_valid),
        .rd_req_row   (rd_req_row),
        .cur_blk      (cur_blk),
        .rec_valid    (rec_valid),
        .rec_bad      (rec_bad),
        .clear_tbl    (clear_tbl),
        .table_ready  (table_ready),
        .scan_busy    (scan_busy),
        .scan_done    (scan_done)
    );

    assign mark_en = mark_bad_valid && table_ready &&
                     ({1'b0, mark_bad_block} < N_BLK);

    bbt_bitmap #(.NUM_BLOCKS(NUM_BLOCKS)) u_map (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (clear_tbl),
        .wr_en        (rec_valid),
        .wr_blk       (cur_blk),
        .wr_bad       (rec_bad),
        .mark_en      (mark_en),
        .mark_blk     (mark_bad_block),
        .rd_blk       (query_block),
        .rd_bad       (tbl_rd_bad),
        .mark_was_bad (mark_was_bad)
    );

    bbt_counter #(.NUM_BLOCKS(NUM_BLOCKS), .MIN_GOOD(MIN_GOOD)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clear_tbl),
        .inc       (rec_valid && !rec_bad),
        .dec       (mark_en && !mark_was_bad),
        .count     (good_count),
        .below_min (below_min)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            query_bad_q <= 1'b1;
        else
            query_bad_q <= !table_ready || ({1'b0, query_block} >= N_BLK) || tbl_rd_bad;
    end

    assign query_bad    = query_bad_q;
    assign table_valid  = table_ready;
    assign device_fault = table_ready && below_min;
    assign rd_req_spare = 1'b1;
    assign rd_req_off   = 4'(MARKER_OFF);

    AST_QUERY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !table_valid |=> query_bad); // R8

    AST_FAULT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        device_fault |-> table_valid); // R6

    AST_COUNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        table_valid && $past(table_valid) |-> good_count <= $past(good_count)); // R9

endmodule

// File: tb/bbt_builder_bench.sv
module bbt_builder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NB   = 60;
    localparam int PPB  = 4;
    localparam int MING = 56;
    localparam int BW   = $clog2(NB);
    localparam int RW   = BW + $clog2(PPB);
    localparam int CW   = $clog2(NB + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic rd_req_valid, rd_req_spare, query_bad, table_valid, scan_busy, scan_done, device_fault;
    logic rd_req_ready = 1'b0;
    logic rd_rsp_valid = 1'b0;
    logic [7:0] rd_rsp_byte = 8'h00;
    logic [RW-1:0] rd_req_row;
    logic [3:0] rd_req_off;
    logic mark_bad_valid = 1'b0;
    logic [BW-1:0] mark_bad_block = '0;
    logic [BW-1:0] query_block = '0;
    logic [CW-1:0] good_count;

    int errors = 0;
    int checks = 0;
    int pat = 1;
    int exp_blk = 0;
    int phase = 0;
    int dly = 0;
    int cur = 0;
    int cycles = 0;
    bit timed_out = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cycles++;

    bbt_builder #(.NUM_BLOCKS(NB), .PAGES_PER_BLOCK(PPB), .MIN_GOOD(MING)) u_bbt_builder (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_row(rd_req_row), .rd_req_spare(rd_req_spare), .rd_req_off(rd_req_off),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_byte(rd_rsp_byte),
        .mark_bad_valid(mark_bad_valid), .mark_bad_block(mark_bad_block),
        .query_block(query_block), .query_bad(query_bad),
        .table_valid(table_valid), .scan_busy(scan_busy), .scan_done(scan_done),
        .good_count(good_count), .device_fault(device_fault)
    );

    function automatic logic [7:0] marker(input int p, input int b);
        if (p == 1) begin
            if (b % 7 == 3)  return 8'h00;
            if (b % 11 == 5) return 8'hF0;
            return 8'hFF;
        end
        return (b % 16 == 15) ? 8'h7F : 8'hFF;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // sequencer model: variable accept and response latency
    always @(negedge clk) begin
        rd_rsp_valid = 1'b0;
        case (phase)
            0: if (rd_req_valid) begin
                cur = int'(rd_req_row) / PPB;
                check(cur == exp_blk, "R1 block order", cur, exp_blk);
                check(int'(rd_req_row) == exp_blk * PPB, "R3 row", int'(rd_req_row), exp_blk * PPB);
                check(rd_req_off == 4'd5 && rd_req_spare, "R3 offset", int'(rd_req_off), 5);
                exp_blk++;
                dly = cur % 3;
                if (dly == 0) begin rd_req_ready = 1'b1; phase = 2; end
                else phase = 1;
            end
            1: begin
                check(rd_req_valid && int'(rd_req_row) == cur * PPB, "R2 hold", int'(rd_req_row), cur * PPB);
                dly--;
                if (dly == 0) begin rd_req_ready = 1'b1; phase = 2; end
            end
            2: begin
                rd_req_ready = 1'b0;
                if (cur % 2 == 0) begin
                    rd_rsp_valid = 1'b1; rd_rsp_byte = marker(pat, cur); phase = 0;
                end else phase = 3;
            end
            default: begin
                rd_rsp_valid = 1'b1; rd_rsp_byte = marker(pat, cur); phase = 0;
            end
        endcase
    end

    task automatic wait_done();
        int n = 0;
        while (!scan_done && n < 5000) begin @(negedge clk); n++; end
        if (!scan_done) begin
            timed_out = 1'b1;
            check(1'b0, "R7 watchdog", n, 0);
        end
    endtask

    task automatic query_all(input int p, input string req);
        for (int b = 0; b < 64; b++) begin
            query_block = BW'(b);
            @(negedge clk);
            if (b >= NB) check(query_bad == 1'b1, "R8 out of range", int'(query_bad), 1);
            else check(query_bad == (marker(p, b) != 8'hFF), req, int'(query_bad),
                       int'(marker(p, b) != 8'hFF));
        end
    endtask

    task automatic mark(input int b);
        mark_bad_block = BW'(b);
        mark_bad_valid = 1'b1;
        @(negedge clk);
        mark_bad_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int good;
        repeat (3) @(negedge clk);
        check(!rd_req_valid && !table_valid && good_count == 0 && !scan_done &&
              !device_fault && query_bad, "R10 reset", int'(rd_req_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        query_block = '0;
        // scan 1
        pat = 1; exp_blk = 0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        check(scan_busy && !table_valid, "R1 busy", int'(scan_busy), 1);
        check(query_bad == 1'b1, "R8 query during scan", int'(query_bad), 1);
        start = 1'b1; @(negedge clk); start = 1'b0;   // R11 ignored
        mark_bad_block = '0; mark_bad_valid = 1'b1; @(negedge clk); mark_bad_valid = 1'b0; // R9 ignored
        wait_done();
        if (!timed_out) begin
            check(table_valid, "R7 done with valid", int'(table_valid), 1);
            @(negedge clk);
            check(!scan_done, "R7 pulse width", int'(scan_done), 0);
            check(exp_blk == NB, "R11 single pass", exp_blk, NB);
            good = 0;
            for (int b = 0; b < NB; b++) if (marker(1, b) == 8'hFF) good++;
            check(int'(good_count) == good, "R5 count", int'(good_count), good);
            check(device_fault == (good < MING), "R6 fault", int'(device_fault), int'(good < MING));
            query_all(1, "R4 table pattern1");
            query_block = '0; @(negedge clk);
            check(query_bad == 1'b0, "R9 mark during scan ignored", int'(query_bad), 0);
            // rescan
            pat = 2; exp_blk = 0;
            start = 1'b1; @(negedge clk); start = 1'b0;
            check(!table_valid && good_count == 0, "R12 invalidated", int'(good_count), 0);
            wait_done();
        end
        if (!timed_out) begin
            @(negedge clk);
            good = 0;
            for (int b = 0; b < NB; b++) if (marker(2, b) == 8'hFF) good++;
            check(int'(good_count) == good, "R12 recount", int'(good_count), good);
            check(device_fault == (good < MING), "R6 at bound", int'(device_fault), int'(good < MING));
            query_all(2, "R12 table pattern2");
            mark(3); good--;
            check(int'(good_count) == good, "R9 mark dec", int'(good_count), good);
            check(device_fault == (good < MING), "R6 equal min", int'(device_fault), int'(good < MING));
            query_block = BW'(3); @(negedge clk);
            check(query_bad == 1'b1, "R9 marked bad", int'(query_bad), 1);
            mark(3);
            check(int'(good_count) == good, "R9 repeat mark", int'(good_count), good);
            mark(15);
            check(int'(good_count) == good, "R9 mark bad block", int'(good_count), good);
            mark(62);
            check(int'(good_count) == good, "R9 out of range mark", int'(good_count), good);
            mark(4); good--;
            check(device_fault == (good < MING), "R6 below min", int'(device_fault), int'(good < MING));
            check(!rd_req_valid, "R1 no read in ready", int'(rd_req_valid), 0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL R7 global watchdog actual=%0d expected=0", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule